// File: doc/BRIEF.md
# Sequential Signed Divider with Remainder and Modulus

This block divides one two's-complement integer by another and returns three results from one operation. The quotient is truncated toward zero. The remainder takes the sign of the dividend. The modulus takes the sign of the divisor. A caller presents both operands together with a one-cycle start strobe. The block then works on the operand magnitudes and settles one quotient bit per clock, using a restoring shift-and-subtract loop. A single extra cycle after the loop applies the signs to the three results.

While an operation is in flight, `busy` is high and any further start strobe is dropped. When the results are ready, `done` pulses for one cycle. The results and the two flags then stay unchanged until the next operation finishes. A zero divisor raises a divide-by-zero flag and forces all three results to zero. The single case that cannot be represented, the most negative value divided by minus one, raises an overflow flag.

Top module: `sdiv_rem_mod`

## Requirements
- R1: When the divisor is non-zero and there is no overflow, `quotient` equals the dividend divided by the divisor, truncated toward zero. It is negative exactly when the operand signs differ and the magnitude quotient is non-zero.
- R2: `remainder` equals dividend − quotient·divisor. It is zero or carries the sign of the dividend. Examples: 11, 4 gives 3; −11, 4 gives −3.
- R3: `modulus` equals `remainder` when the remainder is zero or has the sign of the divisor; otherwise it equals remainder + divisor. Examples: 9, 4 gives 1; 7, −4 gives −1; −11, 4 gives 1.
- R4: With `W`-bit operands, `done` is high for exactly one cycle, W+1 clock edges after the edge that samples `start`. `busy` is high from the cycle after that edge up to, but not including, the `done` cycle.
- R5: `quotient`, `remainder`, `modulus`, `divZero` and `overflow` change only at the edge that raises `done`. They hold their values until the next operation completes.
- R6: A `start` seen while `busy` is high is ignored. It produces no extra `done` pulse and does not alter the running operation.
- R7: A zero divisor sets `divZero` with `done` and forces the three results to zero, with `overflow` low.
- R8: The dividend 100…0 (the most negative value) divided by −1 (all ones) sets `overflow` with `done`. `quotient` then returns the dividend, and `remainder` and `modulus` are zero.
- R9: After reset, `busy`, `done`, both flags and all three results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; the operands are sampled with it when idle |
| dividend | input | W | Two's-complement dividend |
| divisor | input | W | Two's-complement divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | W | Quotient truncated toward zero |
| remainder | output | W | Residue with the sign of the dividend |
| modulus | output | W | Residue with the sign of the divisor |
| divZero | output | 1 | The last operation had a zero divisor |
| overflow | output | 1 | The last operation was the most negative value divided by −1 |

## Verification
Delivering one result and accepting the next request can fall in the same cycle. In the cycle where `done` is high, `busy` is already low, so a new `start` placed there must be accepted. That start must not disturb the result currently on the outputs. The bench's driver always issues the next operation at the first idle cycle, so every back-to-back pair lands in the `done` cycle. The scoreboard then compares the outputs seen with that `done` against the earlier operation's expected values. It also checks that the following `done` arrives exactly W+1 edges after its own start.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;  // capture operands and magnitudes
    logic step;  // one restoring iteration
    logic fix;   // apply signs and publish results
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output ctlStrobes_t strb
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(W - 1);

  divState_t        state;
  logic [CNT_W-1:0] iterCnt;
  logic             doneR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= (state == ST_FIX);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST_ITER) state <= ST_FIX;
          else iterCnt <= iterCnt + 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
    strb.fix  = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;

endmodule

// File: rtl/sdiv_dpath.sv
module sdiv_dpath
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  strb,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] modulus,
  output logic         divZero,
  output logic         overflow
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // iteration state
  logic [W-1:0] quoSh;     // dividend magnitude shifting out, quotient bits in
  logic [W:0]   remSh;     // partial remainder
  logic [W-1:0] divMag;    // divisor magnitude
  logic [W-1:0] divisorR;  // signed divisor kept for the modulus fix-up
  logic         negA;
  logic         negB;
  logic         zeroB;
  logic         ovfR;

  // operand magnitudes (the most negative value maps to 2^(W-1) unsigned)
  logic [W-1:0] absA;
  logic [W-1:0] absB;
  assign absA = dividend[W-1] ? (~dividend + 1'b1) : dividend;
  assign absB = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;

  // one restoring iteration
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         fits;
  assign shifted = {remSh[W-1:0], quoSh[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, divMag};
  assign fits    = ~trial[W+1];

  // sign correction
  logic [W-1:0] qMag;
  logic [W-1:0] rMag;
  logic [W-1:0] qSigned;
  logic [W-1:0] rSigned;
  logic [W-1:0] mSigned;
  logic         signsDiffer;
  assign qMag        = quoSh;
  assign rMag        = remSh[W-1:0];
  assign signsDiffer = negA ^ negB;
  assign qSigned     = signsDiffer ? (~qMag + 1'b1) : qMag;
  assign rSigned     = negA ? (~rMag + 1'b1) : rMag;
  assign mSigned     = ((rMag != '0) && signsDiffer) ? (rSigned + divisorR) : rSigned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoSh    <= '0;
      remSh    <= '0;
      divMag   <= '0;
      divisorR <= '0;
      negA     <= 1'b0;
      negB     <= 1'b0;
      zeroB    <= 1'b0;
      ovfR     <= 1'b0;
    end else if (strb.load) begin
      quoSh    <= absA;
      remSh    <= '0;
      divMag   <= absB;
      divisorR <= divisor;
      negA     <= dividend[W-1];
      negB     <= divisor[W-1];
      zeroB    <= (divisor == '0);
      ovfR     <= (dividend == MOST_NEG) && (divisor == '1);
    end else if (strb.step) begin
      remSh <= fits ? trial[W:0] : shifted;
      quoSh <= {quoSh[W-2:0], fits};
    end
  end

  // published results: updated only in the fix-up cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      modulus   <= '0;
      divZero   <= 1'b0;
      overflow  <= 1'b0;
    end else if (strb.fix) begin
      if (zeroB) begin
        quotient  <= '0;
        remainder <= '0;
        modulus   <= '0;
        divZero   <= 1'b1;
        overflow  <= 1'b0;
      end else begin
        quotient  <= qSigned;
        remainder <= rSigned;
        modulus   <= mSigned;
        divZero   <= 1'b0;
        overflow  <= ovfR;
      end
    end
  end

endmodule

// File: rtl/sdiv_rem_mod.sv
module sdiv_rem_mod
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] modulus,
  output logic         divZero,
  output logic         overflow
);

  ctlStrobes_t strb;

  sdiv_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .strb  (strb)
  );

  sdiv_dpath #(.W(W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .modulus   (modulus),
    .divZero   (divZero),
    .overflow  (overflow)
  );

endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] modulus,
  input logic         divZero,
  input logic         overflow
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  int busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else if (start) busyLen <= 0;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyLen == W + 1));

  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(modulus)
               && $stable(divZero) && $stable(overflow)));

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (quotient == '0 && remainder == '0 && modulus == '0 && !overflow));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (quotient == MOST_NEG && remainder == '0 && modulus == '0));

  // R3
  mod_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remainder != '0 && modulus != remainder) |-> (modulus[W-1] != remainder[W-1]));

endmodule

bind sdiv_rem_mod sdiv_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .modulus   (modulus),
  .divZero   (divZero),
  .overflow  (overflow)
);

// File: tb/sdiv_rem_mod_tb_top.sv
module sdiv_rem_mod_tb_top;

  localparam int W = 16;
  localparam int MIN_I = -(1 << (W - 1));
  localparam int MAX_I = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic [W-1:0] modulus;
  logic         divZero;
  logic         overflow;

  always #5 clk = ~clk;

  sdiv_rem_mod #(.W(W)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .modulus   (modulus),
    .divZero   (divZero),
    .overflow  (overflow)
  );

  typedef struct {
    int q;
    int r;
    int m;
    bit dz;
    bit ov;
    int issue;
  } expItem_t;

  expItem_t expQ[$];
  int cycleCnt = 0;
  int checks = 0;
  int errors = 0;
  int doneCount = 0;
  int lastQ = 0;
  int lastR = 0;
  int lastM = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int wrap(input int v);
    logic [W-1:0] t;
    t = v[W-1:0];
    return sx(t);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: waits for idle, issues one op, pushes the expected item
  task automatic issue(input int a, input int b);
    expItem_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start    = 1'b1;
    dividend = a[W-1:0];
    divisor  = b[W-1:0];
    e.issue  = cycleCnt + 1;
    if (b == 0) begin
      e.q = 0; e.r = 0; e.m = 0; e.dz = 1; e.ov = 0;
    end else begin
      e.dz = 0;
      e.ov = (a == MIN_I) && (b == -1);
      e.q  = wrap(a / b);
      e.r  = a % b;
      e.m  = (e.r != 0 && ((e.r < 0) != (b < 0))) ? e.r + b : e.r;
    end
    expQ.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // start pulse while busy: must be dropped (R6)
  task automatic pokeWhileBusy(input int a, input int b);
    @(negedge clk);
    while (!busy) @(negedge clk);
    @(negedge clk);
    start    = 1'b1;
    dividend = a[W-1:0];
    divisor  = b[W-1:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard comparison when done is seen
  always @(negedge clk) begin
    if (rstN && done) begin
      doneCount++;
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 unexpected done: got 1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check("R1 quotient", sx(quotient), e.q);
        check("R2 remainder", sx(remainder), e.r);
        check("R3 modulus", sx(modulus), e.m);
        check("R7 divZero", int'(divZero), int'(e.dz));
        check("R8 overflow", int'(overflow), int'(e.ov));
        check("R4 latency", cycleCnt - e.issue, W + 1);
        check("R4 busy low with done", int'(busy), 0);
      end
      lastQ = sx(quotient);
      lastR = sx(remainder);
      lastM = sx(modulus);
    end
  end

  initial begin
    int seed;
    int dc;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 quotient", sx(quotient), 0);
    check("R9 remainder", sx(remainder), 0);
    check("R9 modulus", sx(modulus), 0);
    check("R9 flags", int'(divZero) + int'(overflow), 0);
    rstN = 1'b1;
    @(negedge clk);

    // sign cases for R1 R2 R3
    issue(11, 4);
    issue(-11, 4);
    issue(9, 4);
    issue(7, -4);
    issue(-7, -4);
    issue(0, 5);
    issue(100, 7);
    issue(-100, -7);
    issue(3, 5);
    issue(-1, MIN_I);
    issue(MAX_I, MIN_I);
    issue(MIN_I, 1);
    issue(MIN_I, 3);
    // R8 overflow case
    issue(MIN_I, -1);
    // R7 zero divisor
    issue(5, 0);
    issue(-3, 0);
    issue(MIN_I, 0);
    issue(12, 12);
    drain();

    // R5 outputs hold after done
    repeat (5) @(negedge clk);
    check("R5 quotient hold", sx(quotient), lastQ);
    check("R5 remainder hold", sx(remainder), lastR);
    check("R5 modulus hold", sx(modulus), lastM);

    // R6 start while busy is dropped
    dc = doneCount;
    issue(-50, 6);
    pokeWhileBusy(1000, 3);
    pokeWhileBusy(7, 0);
    drain();
    repeat (W + 4) @(negedge clk);
    check("R6 done pulses", doneCount - dc, 1);

    // pseudo-random operands, back to back
    seed = 32'h1357_2468;
    for (int i = 0; i < 60; i++) begin
      int a;
      int b;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      a = wrap(seed);
      b = wrap(seed >>> 16);
      if (i % 5 == 0) b = wrap(b % 9);
      issue(a, b);
    end
    drain();
    repeat (5) @(negedge clk);
    check("R5 final hold", sx(modulus), lastM);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule